// File: doc/BRIEF.md
# Two-Channel Sequential Bus Breakpoint Unit

This block watches every bus cycle a processor issues and compares it against two independently programmed breakpoint channels, A and B. Each channel checks the access address, the access size, which bus carried the cycle and, when enabled, the data value under a per-bit mask. A matching cycle produces a one-cycle break request one clock later, together with the address of the cycle that matched. Exception entry then reports that address and does not execute the instruction there.

A sequential mode turns the pair into a two-step trigger. A channel A match arms the unit without breaking. Only a later channel B match raises the break. An optional execution counter makes the break wait for the Nth qualifying channel B match. Software programs all settings through a simple write-only register port.

Top module: `bus_break_unit`

## Requirements
- R1: An access matches a channel address when both agree after clearing the low address bits the access size spans. Sizes are `mon_size` 0 = byte (no bits cleared), 1 = word (bit 0 cleared) and 2 = longword (bits 1:0 cleared). A channel programmed with 0x1003 therefore matches a longword at 0x1000, a word at 0x1002 and a byte at 0x1003.
- R2: Each channel's address mask register (sel 1 for A, sel 6 for B) marks with a 1 the address bits that are not compared.
- R3: A channel's configuration register (sel 4 for A, sel 9 for B) holds: bit 0 enable, bit 1 data compare, bits 3:2 size filter (0 any, 1 byte, 2 word, 3 longword), bit 4 required `mon_bus` value and bit 5 any-bus. A cycle whose size or bus fails the filter does not match.
- R4: With data compare on, a channel matches only when the address and the data both match. The data value sits at sel 2/7 and the data mask at sel 3/8, and a mask bit of 1 means don't care.
- R5: Data is lane-placed, little-endian, on `mon_data`. A byte access compares its lane, `mon_data[8*a+7:8*a]` with a = address bits 1:0, against bits 15:8 of the value and mask when address bit 0 is set and bits 7:0 otherwise. Software therefore replicates the byte in both places. A word access compares its half against bits 15:0. For byte and word accesses, bits 31:16 of the value and mask are ignored.
- R6: `brk_req` is high for exactly the clock after a matching cycle with `mon_valid` high, and `brk_addr` then holds that cycle's address. There is no break while `mon_valid` is low or the channel is disabled.
- R7: With sequential mode off (control register sel 10, bit 0 = 0), a match on either channel breaks.
- R8: With sequential mode on, a channel A match arms the unit and gives no break. A channel B match breaks only when the unit is armed, and the break disarms it. A channel B match while disarmed is ignored.
- R9: In sequential mode, a cycle that matches A and B together gives no break. The A part still arms the unit.
- R10: While sequential mode is off the unit is disarmed, so clearing the sequential bit discards a pending channel A match.
- R11: With count mode on (control bit 1), a channel B match that would break instead decrements the counter while the counter exceeds 1, and breaks when the counter is 0 or 1. Writing sel 11 reloads the counter, and that write wins over a decrement in the same cycle.
- R12: After reset every register is zero, all channels are disabled and `brk_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| mon_valid | input | 1 | Bus cycle valid |
| mon_addr | input | ADDR_W | Bus cycle byte address |
| mon_data | input | 32 | Bus cycle data, lane-placed |
| mon_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| mon_bus | input | 1 | Which bus carried the cycle |
| brk_req | output | 1 | One-cycle break request |
| brk_addr | output | ADDR_W | Address of the cycle that matched |

## Verification
The bench sweeps every programmed low address against every aligned access of every size. A design that aligned the wrong bits, or compared the exact address, would break on a neighbouring longword or miss the word containing the target byte. It walks the data value through every byte lane and both word halves with foreign bytes on the other lanes, which catches a compare on the wrong lane or on the upper value bits. In sequential mode it drives B before A, A and B together, A then a cleared sequential bit, and counted B matches. These cases expose a unit that breaks on an unarmed B, on a simultaneous match, on a stale arm, or one hit too early or too late.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_e;

  // channel configuration, enable in bit 0
  typedef struct packed {
    logic       anybus;
    logic       bus;
    logic [1:0] size_sel;
    logic       dcmp;
    logic       en;
  } chan_cfg_t;

  localparam int unsigned CFG_W     = 6;
  localparam int unsigned CH_STRIDE = 5;

  // offsets inside one channel's register group
  localparam logic [3:0] RO_ADDR = 4'd0;
  localparam logic [3:0] RO_AMSK = 4'd1;
  localparam logic [3:0] RO_DATA = 4'd2;
  localparam logic [3:0] RO_DMSK = 4'd3;
  localparam logic [3:0] RO_CFG  = 4'd4;

  localparam logic [3:0] RS_CTRL  = 4'd10;
  localparam logic [3:0] RS_COUNT = 4'd11;

endpackage

// File: rtl/bbu_regfile.sv
module bbu_regfile
  import bbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NCH    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [3:0]                    sel,
  input  logic [31:0]                   wdata,
  output logic [NCH-1:0][ADDR_W-1:0]    ch_addr,
  output logic [NCH-1:0][ADDR_W-1:0]    ch_amsk,
  output logic [NCH-1:0][31:0]          ch_data,
  output logic [NCH-1:0][31:0]          ch_dmsk,
  output chan_cfg_t [NCH-1:0]           ch_cfg,
  output logic                          seq_mode,
  output logic                          cnt_mode,
  output logic                          cnt_load,
  output logic [CNT_W-1:0]              cnt_val
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [3:0] BASE = 4'(c * CH_STRIDE);

    logic [ADDR_W-1:0] addr_q, amsk_q;
    logic [31:0]       data_q, dmsk_q;
    chan_cfg_t         cfg_q;
    logic              wr_addr, wr_amsk, wr_data, wr_dmsk, wr_cfg;

    always_comb begin
      wr_addr = we && (sel == BASE + RO_ADDR);
      wr_amsk = we && (sel == BASE + RO_AMSK);
      wr_data = we && (sel == BASE + RO_DATA);
      wr_dmsk = we && (sel == BASE + RO_DMSK);
      wr_cfg  = we && (sel == BASE + RO_CFG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        amsk_q <= '0;
        data_q <= '0;
        dmsk_q <= '0;
        cfg_q  <= '0;
      end else begin
        if (wr_addr) addr_q <= wdata[ADDR_W-1:0];
        if (wr_amsk) amsk_q <= wdata[ADDR_W-1:0];
        if (wr_data) data_q <= wdata;
        if (wr_dmsk) dmsk_q <= wdata;
        if (wr_cfg)  cfg_q  <= chan_cfg_t'(wdata[CFG_W-1:0]);
      end
    end

    assign ch_addr[c] = addr_q;
    assign ch_amsk[c] = amsk_q;
    assign ch_data[c] = data_q;
    assign ch_dmsk[c] = dmsk_q;
    assign ch_cfg[c]  = cfg_q;
  end

  logic wr_ctrl;
  logic seq_q, cntm_q;

  always_comb begin
    wr_ctrl  = we && (sel == RS_CTRL);
    cnt_load = we && (sel == RS_COUNT);
    cnt_val  = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= 1'b0;
      cntm_q <= 1'b0;
    end else if (wr_ctrl) begin
      seq_q  <= wdata[0];
      cntm_q <= wdata[1];
    end
  end

  assign seq_mode = seq_q;
  assign cnt_mode = cntm_q;

endmodule

// File: rtl/bbu_chan_match.sv
module bbu_chan_match
  import bbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  chan_cfg_t         cfg,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [ADDR_W-1:0] prog_amsk,
  input  logic [31:0]       prog_data,
  input  logic [31:0]       prog_dmsk,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [31:0]       mon_data,
  input  logic [1:0]        mon_size,
  input  logic              mon_bus,
  output logic              hit
);

  logic [ADDR_W-1:0] align;
  logic [31:0]       act, expv, ign;
  logic [7:0]        lane_b, exp_b, msk_b;
  logic [15:0]       lane_w;
  logic              addr_ok, size_ok, bus_ok, data_ok;

  always_comb begin
    unique case (mon_size)
      SZ_BYTE: align = '0;
      SZ_WORD: align = ADDR_W'(2'b01);
      default: align = ADDR_W'(2'b11);
    endcase
    addr_ok = ((mon_addr ^ prog_addr) & ~(prog_amsk | align)) == '0;
    size_ok = (cfg.size_sel == 2'd0) || (cfg.size_sel == mon_size + 2'd1);
    bus_ok  = cfg.anybus || (cfg.bus == mon_bus);

    unique case (mon_addr[1:0])
      2'd0:    lane_b = mon_data[7:0];
      2'd1:    lane_b = mon_data[15:8];
      2'd2:    lane_b = mon_data[23:16];
      default: lane_b = mon_data[31:24];
    endcase
    exp_b  = mon_addr[0] ? prog_data[15:8] : prog_data[7:0];
    msk_b  = mon_addr[0] ? prog_dmsk[15:8] : prog_dmsk[7:0];
    lane_w = mon_addr[1] ? mon_data[31:16] : mon_data[15:0];

    unique case (mon_size)
      SZ_BYTE: begin
        act  = {24'h0, lane_b};
        expv = {24'h0, exp_b};
        ign  = {24'hFF_FFFF, msk_b};
      end
      SZ_WORD: begin
        act  = {16'h0, lane_w};
        expv = {16'h0, prog_data[15:0]};
        ign  = {16'hFFFF, prog_dmsk[15:0]};
      end
      default: begin
        act  = mon_data;
        expv = prog_data;
        ign  = prog_dmsk;
      end
    endcase
    data_ok = !cfg.dcmp || (((act ^ expv) & ~ign) == 32'h0);

    hit = mon_valid && cfg.en && addr_ok && size_ok && bus_ok && data_ok;
  end

endmodule

// File: rtl/bbu_seq_ctrl.sv
module bbu_seq_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic              hit_a,
  input  logic              hit_b,
  input  logic              seq_mode,
  input  logic              cnt_mode,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              brk_req,
  output logic [ADDR_W-1:0] brk_addr
);

  logic              armed_q, armed_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              brk_q, brk_d;
  logic [ADDR_W-1:0] addr_q;
  logic              b_evt, cnt_fire, a_brk, b_brk;

  always_comb begin
    b_evt    = seq_mode ? (hit_b && !hit_a && armed_q) : hit_b;
    cnt_fire = !cnt_mode || (cnt_q <= CNT_W'(1));
    b_brk    = b_evt && cnt_fire;
    a_brk    = !seq_mode && hit_a;
    brk_d    = a_brk || b_brk;

    if (!seq_mode)  armed_d = 1'b0;
    else if (b_brk) armed_d = 1'b0;
    else if (hit_a) armed_d = 1'b1;
    else            armed_d = armed_q;

    if (cnt_load)                                        cnt_d = cnt_val;
    else if (cnt_mode && b_evt && (cnt_q > CNT_W'(1)))   cnt_d = cnt_q - CNT_W'(1);
    else                                                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      brk_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      brk_q   <= brk_d;
      if (brk_d) addr_q <= mon_addr;
    end
  end

  assign brk_req  = brk_q;
  assign brk_addr = addr_q;

  a_r6_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(mon_valid));

  a_r6_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_addr == $past(mon_addr)));

  a_r8_break_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(seq_mode)) |-> $past(armed_q));

  a_r9_no_simultaneous: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && hit_a && hit_b) |=> !brk_req);

  a_r10_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mode |=> !armed_q);

  a_r11_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && !hit_a && hit_b && (cnt_q > CNT_W'(1))) |=> !brk_req);

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [31:0]       mon_data,
  input  logic [1:0]        mon_size,
  input  logic              mon_bus,
  output logic              brk_req,
  output logic [ADDR_W-1:0] brk_addr
);

  localparam int unsigned NCH = 2;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NCH-1:0][ADDR_W-1:0] ch_addr, ch_amsk;
  logic [NCH-1:0][31:0]       ch_data, ch_dmsk;
  chan_cfg_t [NCH-1:0]        ch_cfg;
  logic                       seq_mode, cnt_mode, cnt_load;
  logic [CNT_W-1:0]           cnt_val;
  logic [NCH-1:0]             hit;

  bbu_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NCH(NCH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (reg_we),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .ch_addr  (ch_addr),
    .ch_amsk  (ch_amsk),
    .ch_data  (ch_data),
    .ch_dmsk  (ch_dmsk),
    .ch_cfg   (ch_cfg),
    .seq_mode (seq_mode),
    .cnt_mode (cnt_mode),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_match
    bbu_chan_match #(.ADDR_W(ADDR_W)) u_match (
      .cfg       (ch_cfg[c]),
      .prog_addr (ch_addr[c]),
      .prog_amsk (ch_amsk[c]),
      .prog_data (ch_data[c]),
      .prog_dmsk (ch_dmsk[c]),
      .mon_valid (mon_valid),
      .mon_addr  (mon_addr),
      .mon_data  (mon_data),
      .mon_size  (mon_size),
      .mon_bus   (mon_bus),
      .hit       (hit[c])
    );
  end

  bbu_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mon_valid (mon_valid),
    .mon_addr  (mon_addr),
    .hit_a     (hit[0]),
    .hit_b     (hit[1]),
    .seq_mode  (seq_mode),
    .cnt_mode  (cnt_mode),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .brk_req   (brk_req),
    .brk_addr  (brk_addr)
  );

endmodule

// File: tb/bus_break_unit_test.sv
`timescale 1ns/1ps
module bus_break_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        mon_valid;
  logic [31:0] mon_addr, mon_data;
  logic [1:0]  mon_size;
  logic        mon_bus;
  logic        brk_req;
  logic [31:0] brk_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic        got_req;
  logic [31:0] got_addr;

  always #2.5 clk = ~clk;

  bus_break_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mon_valid(mon_valid), .mon_addr(mon_addr),
    .mon_data(mon_data), .mon_size(mon_size), .mon_bus(mon_bus),
    .brk_req(brk_req), .brk_addr(brk_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // one bus cycle; result sampled at the negedge after the capturing edge
  task automatic access(input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic bus, input logic v);
    @(negedge clk);
    mon_valid = v; mon_addr = a; mon_data = d; mon_size = sz; mon_bus = bus;
    @(negedge clk);
    mon_valid = 1'b0;
    got_req  = brk_req;
    got_addr = brk_addr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    mon_valid = 1'b0; mon_addr = '0; mon_data = '0; mon_size = '0; mon_bus = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: reset state, disabled channels never break
    check("R12 brk_req after reset", 32'(brk_req), 32'h0);
    access(32'h0, 32'h0, 2'd0, 1'b0, 1'b1);
    check("R12 disabled channels", 32'(got_req), 32'h0);

    // R1: alignment sweep, channel A any size, any bus
    wr(4'd1, 32'h0);
    wr(4'd4, 32'h21);
    for (int p = 0; p < 4; p++) begin
      wr(4'd0, 32'h1000 + p);
      for (int sz = 0; sz < 3; sz++) begin
        for (int x = 0; x < 8; x += (1 << sz)) begin
          logic [31:0] alm, a;
          logic        e;
          alm = (sz == 0) ? 32'h0 : (sz == 1) ? 32'h1 : 32'h3;
          a   = 32'h1000 + x;
          e   = ((a & ~alm) == ((32'h1000 + p) & ~alm));
          access(a, 32'h0, 2'(sz), 1'b0, 1'b1);
          check("R1 align match", 32'(got_req), 32'(e));
          if (e) check("R6 captured address", got_addr, a);
        end
      end
    end

    // R6: pulse lasts one cycle; no break without valid
    access(32'h1003, 32'h0, 2'd0, 1'b0, 1'b1);
    check("R6 pulse", 32'(got_req), 32'h1);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(brk_req), 32'h0);
    access(32'h1003, 32'h0, 2'd0, 1'b0, 1'b0);
    check("R6 valid low", 32'(got_req), 32'h0);

    // R2: address mask
    wr(4'd0, 32'h2000);
    wr(4'd1, 32'h0000_00F0);
    for (int k = 0; k < 32; k++) begin
      access(32'h2000 + 32'(k) * 32'h10, 32'h0, 2'd0, 1'b0, 1'b1);
      check("R2 address mask", 32'(got_req), 32'(k < 16));
    end

    // R3: size and bus filters
    wr(4'd0, 32'h3000);
    wr(4'd1, 32'h0);
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        wr(4'd4, {26'h0, 1'b0, 1'(b), 2'(s), 1'b0, 1'b1});
        for (int msz = 0; msz < 3; msz++) begin
          for (int mb = 0; mb < 2; mb++) begin
            logic e;
            e = ((s == 0) || (s == msz + 1)) && (mb == b);
            access(32'h3000, 32'h0, 2'(msz), 1'(mb), 1'b1);
            check("R3 size/bus filter", 32'(got_req), 32'(e));
          end
        end
      end
    end
    wr(4'd4, 32'h0);

    // R4/R5: channel B data compare, address ignored
    wr(4'd5, 32'h4000);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'hDEAD_5A5A);
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h23);
    for (int ln = 0; ln < 4; ln++) begin
      logic [7:0] vals [4];
      vals = '{8'h5A, 8'h5B, 8'hA5, 8'hDE};
      for (int i = 0; i < 4; i++) begin
        logic [31:0] d;
        d = {4{~vals[i]}};
        d[8*ln +: 8] = vals[i];
        access(32'h4000 + 32'(ln), d, 2'd0, 1'b0, 1'b1);
        check("R5 byte lane", 32'(got_req), 32'(vals[i] == 8'h5A));
      end
    end
    wr(4'd7, 32'hBEEF_1234);
    wr(4'd8, 32'h0000_000F);
    for (int h = 0; h < 2; h++) begin
      logic [15:0] ws [4];
      ws = '{16'h1234, 16'h123F, 16'h1244, 16'hBEEF};
      for (int i = 0; i < 4; i++) begin
        logic [31:0] d;
        d = h ? {ws[i], 16'hBEEF} : {16'hBEEF, ws[i]};
        access(32'h4000 + 32'(2 * h), d, 2'd1, 1'b0, 1'b1);
        check("R5 word half, R4 data mask", 32'(got_req), 32'(i < 2));
      end
    end
    wr(4'd7, 32'hCAFE_0000);
    wr(4'd8, 32'h0000_FFFF);
    access(32'h4000, 32'hCAFE_1234, 2'd2, 1'b0, 1'b1);
    check("R4 longword masked", 32'(got_req), 32'h1);
    access(32'h4000, 32'hCAFF_0000, 2'd2, 1'b0, 1'b1);
    check("R4 longword mismatch", 32'(got_req), 32'h0);
    wr(4'd6, 32'h0);
    access(32'h4004, 32'hCAFE_0000, 2'd2, 1'b0, 1'b1);
    check("R4 data ok but address wrong", 32'(got_req), 32'h0);

    // sequential setup: A at 0x5000; B at 0x5000 or 0x4000
    wr(4'd0, 32'h5000); wr(4'd1, 32'h0); wr(4'd4, 32'h21);
    wr(4'd5, 32'h5000); wr(4'd6, 32'h1000); wr(4'd9, 32'h21);

    // R7: non-sequential, either channel breaks
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R7 B alone", 32'(got_req), 32'h1);
    access(32'h5000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R7 A", 32'(got_req), 32'h1);

    // R8 / R9
    wr(4'd10, 32'h1);
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R8 B before A", 32'(got_req), 32'h0);
    access(32'h5000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R9 simultaneous", 32'(got_req), 32'h0);
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R8 B after A", 32'(got_req), 32'h1);
    check("R8 address", got_addr, 32'h4000);
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R8 disarmed after break", 32'(got_req), 32'h0);

    // R10: clearing sequential bit drops the arm
    access(32'h5000, 32'h0, 2'd2, 1'b0, 1'b1);
    wr(4'd10, 32'h0);
    wr(4'd10, 32'h1);
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R10 arm cleared", 32'(got_req), 32'h0);

    // R11: counted sequential break
    wr(4'd10, 32'h3);
    wr(4'd11, 32'd3);
    access(32'h5000, 32'h0, 2'd2, 1'b0, 1'b1);
    for (int n = 0; n < 3; n++) begin
      access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
      check("R11 count", 32'(got_req), 32'(n == 2));
    end
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R11 disarmed", 32'(got_req), 32'h0);
    wr(4'd11, 32'd1);
    access(32'h5000, 32'h0, 2'd2, 1'b0, 1'b1);
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R11 count one", 32'(got_req), 32'h1);

    // R11: non-sequential counted B
    wr(4'd10, 32'h2);
    wr(4'd11, 32'd2);
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R11 nonseq first", 32'(got_req), 32'h0);
    access(32'h4000, 32'h0, 2'd2, 1'b0, 1'b1);
    check("R11 nonseq second", 32'(got_req), 32'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule